// File: doc/BRIEF.md
# Scaler Step Factor Calculator

This block works out, for one axis of a video scaler, whether the picture is enlarged, reduced or passed through, and the fixed-point step that the scaler's interpolator advances by for each output pixel or line. A controller presents the active input size, the active output size and a bit that picks one of two reduction formulas, then pulses a start strobe. The block classifies the pair of sizes and runs an iterative divider. When the result is ready it presents the mode, the step factor and an error flag together with a one-cycle done pulse.

Enlargement uses 16 fractional bits. The default reduction formula uses 14 fractional bits, and its numerator depends on how large the reduction ratio is. The alternate reduction formula produces the reciprocal step instead. Two instances cover the horizontal and vertical axes. The scaling datapath is a separate block.

Top module: `scale_factor_calc`

## Requirements
- R1: The reported mode is 0 when the input size equals the output size, 1 when the input size is smaller (enlarge) and 2 when the input size is larger (reduce). It is presented with the done pulse.
- R2: In mode 0 the factor is 0 and the error flag is 0.
- R3: In mode 1 the factor is floor((in - 1) * 65536 / (out - 1)).
- R4: In mode 2 with the select bit at 0, and floor((in - 1) / (out - 1)) greater than 2, the factor is floor((in - 1) * 16384 / (out - 1)).
- R5: In mode 2 with the select bit at 0, and floor((in - 1) / (out - 1)) at most 2, the factor is floor((in - 2) * 16384 / (out - 1)).
- R6: In mode 2 with the select bit at 1, the factor is floor(out * 65536 / (in - 1)).
- R7: In mode 1 or 2, an output size of 0 or 1, or an input size of 0, raises the error flag with the done pulse. The factor is then 0 and the mode is still reported.
- R8: Done is high for exactly one cycle per accepted start. Mode, factor and error change only in the cycle where done is high, and hold their values otherwise.
- R9: A start pulse that arrives while a calculation is running is ignored. It neither changes the pending result nor produces an extra done pulse.
- R10: After reset, mode, factor, done and error are all 0.
- R11: Done rises no more than 30 clock edges (SIZE_W + 17) after the edge that samples the start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe, sampled while idle |
| in_size | input | 13 | Active input size on this axis |
| out_size | input | 13 | Active output size on this axis |
| down_alt | input | 1 | Picks the alternate reduction formula when 1 |
| mode | output | 2 | 0 pass-through, 1 enlarge, 2 reduce |
| factor | output | 32 | Fixed-point step factor |
| done | output | 1 | One-cycle result-valid pulse |
| err | output | 1 | Degenerate size reported instead of a division |

## Verification
A mistake in the divider's shift or subtract step shows up as a wrong factor at the next done pulse, 30 edges after start. The bench compares every factor with a wide-integer model, so such a mistake is caught on the first scaling vector. A wrong ratio test or numerator choice appears only in reduction cases near a ratio of 3. For that reason the vectors include ratios just below and exactly at that boundary. A controller that loses track of its state shows up at once, either as a missing or doubled done pulse or as a factor that changes outside done. The bench watches both around every vector and after a start strobe sent while busy.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic [1:0] {
    SCL_SAME = 2'd0,
    SCL_UP   = 2'd1,
    SCL_DOWN = 2'd2
  } scl_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_SHORT = 2'd2
  } scl_state_e;
endpackage

// File: rtl/scl_operands.sv
module scl_operands
  import scl_pkg::*;
#(
  parameter int SIZE_W  = 13,
  parameter int UP_FRAC = 16,
  parameter int DN_FRAC = 14,
  localparam int NUM_W  = SIZE_W + UP_FRAC
) (
  input  logic [SIZE_W-1:0] in_size,
  input  logic [SIZE_W-1:0] out_size,
  input  logic              down_alt,
  output scl_mode_e         mode,
  output logic [NUM_W-1:0]  num,
  output logic [SIZE_W-1:0] den,
  output logic              bad
);
  logic [SIZE_W-1:0] in_m1, in_m2, out_m1, dn_top;
  logic [SIZE_W+1:0] out_x3;
  logic              steep;

  assign in_m1  = in_size - SIZE_W'(1);
  assign in_m2  = in_size - SIZE_W'(2);
  assign out_m1 = out_size - SIZE_W'(1);
  // floor(a/b) > 2 is the same as a >= 3*b
  assign out_x3 = ({2'b00, out_m1} << 1) + {2'b00, out_m1};
  assign steep  = ({2'b00, in_m1} >= out_x3);
  assign dn_top = steep ? in_m1 : in_m2;

  always_comb begin
    num = '0;
    den = out_m1;
    bad = 1'b0;
    if (in_size == out_size) begin
      mode = SCL_SAME;
    end else if (in_size < out_size) begin
      mode = SCL_UP;
      num  = NUM_W'(in_m1) << UP_FRAC;
      bad  = (in_size == '0) || (out_size <= SIZE_W'(1));
    end else begin
      mode = SCL_DOWN;
      bad  = (out_size <= SIZE_W'(1));
      if (down_alt) begin
        num = NUM_W'(out_size) << UP_FRAC;
        den = in_m1;
      end else begin
        num = NUM_W'(dn_top) << DN_FRAC;
      end
    end
  end
endmodule

// File: rtl/scl_divider.sv
module scl_divider #(
  parameter int NUM_W = 29,
  parameter int DEN_W = 13,
  localparam int CNT_W = $clog2(NUM_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             fin,
  output logic [NUM_W-1:0] quo
);
  logic [DEN_W-1:0] den_r, rem;
  logic [NUM_W-1:0] sh;
  logic [CNT_W-1:0] cnt;
  logic [DEN_W:0]   trial, diff;
  logic             fits;

  assign trial = {rem, sh[NUM_W-1]};
  assign diff  = trial - {1'b0, den_r};
  assign fits  = (trial >= {1'b0, den_r});
  assign busy  = (cnt != '0);
  assign quo   = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      den_r <= '0;
      rem   <= '0;
      sh    <= '0;
      cnt   <= '0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load && !busy) begin
        den_r <= den;
        rem   <= '0;
        sh    <= num;
        cnt   <= CNT_W'(NUM_W);
      end else if (busy) begin
        rem <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        sh  <= {sh[NUM_W-2:0], fits};
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) fin <= 1'b1;
      end
    end
  end

  // R11: a load always starts a run of steps
  p_load_busy_r11: assert property (@(posedge clk) disable iff (rst)
    (load && !busy) |=> busy);
  // R8: completion is a single-cycle event
  p_fin_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin);
endmodule

// File: rtl/scale_factor_calc.sv
module scale_factor_calc
  import scl_pkg::*;
#(
  parameter int SIZE_W  = 13,
  parameter int FACT_W  = 32,
  parameter int UP_FRAC = 16,
  parameter int DN_FRAC = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SIZE_W-1:0] in_size,
  input  logic [SIZE_W-1:0] out_size,
  input  logic              down_alt,
  output logic [1:0]        mode,
  output logic [FACT_W-1:0] factor,
  output logic              done,
  output logic              err
);
  localparam int NUM_W = SIZE_W + UP_FRAC;

  scl_mode_e         cur_mode, op_mode;
  logic [NUM_W-1:0]  op_num, quo;
  logic [SIZE_W-1:0] op_den;
  logic              op_bad, pend_err, div_load, div_busy, div_fin;
  scl_state_e        st;

  scl_operands #(.SIZE_W(SIZE_W), .UP_FRAC(UP_FRAC), .DN_FRAC(DN_FRAC)) u_ops (
    .in_size (in_size),
    .out_size(out_size),
    .down_alt(down_alt),
    .mode    (op_mode),
    .num     (op_num),
    .den     (op_den),
    .bad     (op_bad)
  );

  assign div_load = (st == ST_IDLE) && start && (op_mode != SCL_SAME) && !op_bad;

  scl_divider #(.NUM_W(NUM_W), .DEN_W(SIZE_W)) u_div (
    .clk (clk),
    .rst (rst),
    .load(div_load),
    .num (op_num),
    .den (op_den),
    .busy(div_busy),
    .fin (div_fin),
    .quo (quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cur_mode <= SCL_SAME;
      pend_err <= 1'b0;
      mode     <= 2'd0;
      factor   <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          cur_mode <= op_mode;
          pend_err <= op_bad;
          st       <= div_load ? ST_RUN : ST_SHORT;
        end
        ST_RUN: if (div_fin) begin
          mode   <= cur_mode;
          factor <= FACT_W'(quo);
          err    <= 1'b0;
          done   <= 1'b1;
          st     <= ST_IDLE;
        end
        default: begin
          mode   <= cur_mode;
          factor <= '0;
          err    <= pend_err;
          done   <= 1'b1;
          st     <= ST_IDLE;
        end
      endcase
    end
  end

  // R8: single-cycle done
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: outputs move only together with done
  p_factor_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(factor) |-> done);
  // R2: pass-through carries a zero factor
  p_same_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (done && mode == 2'd0) |-> (factor == '0 && !err));
  // R7: an error result carries a zero factor
  p_err_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (factor == '0 && mode != 2'd0));
  // R9: the divider is never reloaded mid-run
  p_no_reload_r9: assert property (@(posedge clk) disable iff (rst)
    div_busy |-> (st == ST_RUN));
endmodule

// File: tb/scale_factor_calc_test.sv
module scale_factor_calc_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  localparam int VIN  [NV] = '{1920, 1280, 3840, 3840, 3840, 8191, 2,    8191, 5, 3, 1, 7, 6, 8190};
  localparam int VOUT [NV] = '{1920, 1920, 1920, 1280, 1920, 2,    8191, 2,    2, 2, 4, 3, 3, 8191};
  localparam int VALT [NV] = '{0,    0,    0,    0,    1,    0,    0,    1,    0, 0, 0, 0, 0, 1};
  localparam int VMODE[NV] = '{0,    1,    2,    2,    2,    2,    1,    2,    2, 2, 1, 2, 2, 1};

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0, down_alt = 1'b0;
  logic [12:0] in_size = '0, out_size = '0;
  logic [1:0]  mode;
  logic [31:0] factor;
  logic        done, err;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scale_factor_calc uut (
    .clk(clk), .rst(rst), .start(start), .in_size(in_size), .out_size(out_size),
    .down_alt(down_alt), .mode(mode), .factor(factor), .done(done), .err(err)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input int a, input int b, input int alt,
                                output int m, output longint f, output int e);
    m = (a == b) ? 0 : ((a < b) ? 1 : 2);
    e = (m != 0 && (b <= 1 || a == 0)) ? 1 : 0;
    f = 0;
    if (m == 1 && e == 0) f = (longint'(a - 1) * 65536) / (b - 1);
    else if (m == 2 && e == 0) begin
      if (alt != 0) f = (longint'(b) * 65536) / (a - 1);
      else if ((a - 1) / (b - 1) > 2) f = (longint'(a - 1) * 16384) / (b - 1);
      else f = (longint'(a - 2) * 16384) / (b - 1);
    end
  endfunction

  // pulse start, wait for done; returns number of edges after the sampling edge
  task automatic run(input int a, input int b, input int alt, output int edges);
    @(negedge clk);
    in_size = 13'(a); out_size = 13'(b); down_alt = alt[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    while (!done && edges < 100) begin
      @(negedge clk);
      edges++;
    end
    edges = edges - 1;
  endtask

  task automatic vec(input int a, input int b, input int alt, input string tag);
    int m, e, edges;
    longint f;
    model(a, b, alt, m, f, e);
    run(a, b, alt, edges);
    check({tag, " R11 latency ok"}, (edges <= 30 && done) ? 1 : 0, 1);
    check({tag, " R1 mode"}, mode, m);
    check({tag, " factor"}, factor, f);
    check({tag, " R7 err"}, err, e);
    @(negedge clk);
    check({tag, " R8 done one cycle"}, done, 0);
    check({tag, " R8 factor held"}, factor, f);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int edges;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 mode", mode, 0);
    check("R10 factor", factor, 0);
    check("R10 done", done, 0);
    check("R10 err", err, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      int m, e;
      longint f;
      model(VIN[i], VOUT[i], VALT[i], m, f, e);
      check("R1 table mode", m, VMODE[i]);
      // R2 R3 R4 R5 R6 covered by the table entries
      vec(VIN[i], VOUT[i], VALT[i], "table");
    end

    // R5 exact value at ratio 2 and R4 at ratio 3
    vec(3840, 1920, 0, "R5 ratio2");
    check("R5 value", factor, 32768);
    vec(7, 3, 0, "R4 ratio3");
    check("R4 value", factor, 49152);
    vec(1920, 1920, 1, "R2 same alt");
    check("R2 value", factor, 0);
    vec(2, 8191, 0, "R3 small");
    check("R3 value", factor, 8);
    vec(8191, 2, 1, "R6 alt");
    check("R6 value", factor, 16);

    // R7 degenerate sizes
    vec(5, 1, 0, "R7 out1");
    check("R7 out1 flag", err, 1);
    vec(0, 5, 0, "R7 in0");
    check("R7 in0 flag", err, 1);
    vec(9, 1, 1, "R7 alt out1");
    vec(4, 0, 0, "R7 out0");
    vec(3, 5, 0, "R7 cleared");

    // R9 start while busy is ignored
    @(negedge clk);
    in_size = 13'd1280; out_size = 13'd1920; down_alt = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    in_size = 13'd1920; out_size = 13'd1920; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 0;
    while (!done && edges < 100) begin
      @(negedge clk);
      edges++;
    end
    begin
      int m, e;
      longint f;
      model(1280, 1920, 0, m, f, e);
      check("R9 mode of first request", mode, 1);
      check("R9 factor of first request", factor, f);
    end
    edges = 0;
    repeat (40) begin
      @(negedge clk);
      if (done) edges++;
    end
    check("R9 no extra done", edges, 0);
    check("R8 factor still held", factor, (longint'(1279) * 65536) / 1919);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule